// File: doc/BRIEF.md
# Register-Mapped Bus Adder

This block is a slave peripheral on a simple synchronous local bus. A host writes two 32-bit operands into word slots 0 and 1. It can read them back, read their wrapping sum from word slot 2, and read a fixed identification word from the last word slot. The shared data path appears as three separate signals: write data in, read data out, and a read output-enable that a pad ring or bus mux would use to drive the lines.

Every bus input first passes through a register stage. The registered word address is decoded one-hot and gated by the control-region select. It is then ANDed with the registered read or write strobe. Each per-word strobe is held open for a fixed number of extra cycles so that slower hosts see stable data. A write is taken once, when its window opens, so a strobe that is held does not reload the register. A short read-valid pulse follows every read strobe.

Top module: `bus_adder_periph`

## Requirements
- R1: A synchronous active-high reset clears both operands, the read output (data 0, output-enable low), the read-valid output and every strobe window.
- R2: With the control select high, a write strobe sampled at clock edge k to word 0 loads operand A, and to word 1 loads operand B. The value loaded is the write data sampled at the same edge, and the new value is in place after edge k+1.
- R3: A write sampled while the control select is low, or a write to any word other than 0 and 1, changes neither operand.
- R4: Reading word 2 returns (A + B) mod 2^32. No carry is reported, and the value follows operand updates made while the read window is open.
- R5: Reading the last word (index 31) returns 0x3564A000. Bits 31:24 hold the vendor code 0x35, bits 23:16 the design code 0x64 and bits 15:0 the revision 0xA000.
- R6: A read of a word other than 0, 1, 2 or 31, or a read sampled with the control select low, keeps output-enable low and data at 0.
- R7: A one-cycle read strobe sampled at edge k gives output-enable high with the selected word on the data lines after edges k+1 through k+4, and output-enable low after edge k+5.
- R8: Read-valid is high after edges k+1 and k+2 for a read strobe sampled at edge k, whatever the address or control select.
- R9: A word's write window stays open while its write strobe is sampled and for 3 cycles after the last sample. A write loads only when the window opens. Strobes sampled while it is already open, including a held strobe with changing data, are ignored.
- R10: A new read strobe ends any open read window and starts a fresh one for the new word, so at most one word is presented at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW (5) | Word address (byte address bits 6:2) |
| ctrl_sel_i | input | 1 | Control-register region select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data |
| rdata_oe_o | output | 1 | Read data output-enable |
| rd_valid_o | output | 1 | Read data valid |

## Verification
An input sampled at edge k reaches the input registers at that edge. Operand loads and the registered read outputs react at edge k+1. The read window then lasts through edge k+4, and read-valid covers edges k+1 and k+2. The bench model advances one step per rising edge, using the bus inputs sampled one edge earlier. It compares all three outputs at the following falling edge, so each result is checked in the exact cycle it is due and in every cycle of its window.

// File: rtl/bap_pkg.sv
package bap_pkg;
  // Fixed word slots of the register map (word index = byte offset / 4)
  localparam int W_OP_A = 0;
  localparam int W_OP_B = 1;
  localparam int W_SUM  = 2;

  // Identification word: vendor code, design code, revision
  localparam logic [7:0]  VENDOR_CODE = 8'h35;
  localparam logic [7:0]  DESIGN_CODE = 8'h64;
  localparam logic [15:0] REVISION    = 16'hA000;
  localparam logic [31:0] ID_WORD     = {VENDOR_CODE, DESIGN_CODE, REVISION};
endpackage

// File: rtl/bap_in_sync.sv
module bap_in_sync #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          ctrl_sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_q,
  output logic          ctrl_sel_q,
  output logic          wr_q,
  output logic          rd_q,
  output logic [DW-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      ctrl_sel_q <= 1'b0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      wdata_q    <= '0;
    end else begin
      addr_q     <= addr_i;
      ctrl_sel_q <= ctrl_sel_i;
      wr_q       <= wr_i;
      rd_q       <= rd_i;
      wdata_q    <= wdata_i;
    end
  end
endmodule

// File: rtl/bap_strobe_ext.sv
// Holds each per-word strobe open for EXT cycles after its last pulse.
// RESTART=1: a new pulse on any bit cancels the window of every other bit.
module bap_strobe_ext #(
  parameter int N       = 32,
  parameter int EXT     = 3,
  parameter bit RESTART = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pulse_i,
  output logic [N-1:0] ext_o
);
  logic [N-1:0] hist [EXT];
  logic [N-1:0] tail;

  always_comb begin
    tail = '0;
    for (int i = 0; i < EXT; i++) tail = tail | hist[i];
  end

  generate
    if (RESTART) begin : g_restart
      always_ff @(posedge clk) begin
        if (rst || (|pulse_i)) begin
          for (int i = 0; i < EXT; i++) hist[i] <= '0;
          if (!rst) hist[0] <= pulse_i;
        end else begin
          hist[0] <= '0;
          for (int i = 1; i < EXT; i++) hist[i] <= hist[i-1];
        end
      end
      assign ext_o = (|pulse_i) ? pulse_i : tail;

      // R10: only one word is ever presented
      a_r10_one_word: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ext_o));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < EXT; i++) hist[i] <= '0;
        end else begin
          hist[0] <= pulse_i;
          for (int i = 1; i < EXT; i++) hist[i] <= hist[i-1];
        end
      end
      assign ext_o = pulse_i | tail;
    end
  endgenerate

  // R7 / R9: a pulse keeps its window open in the following cycle
  a_r7_window_held: assert property (@(posedge clk) disable iff (rst)
    (pulse_i != '0) |=> ((ext_o & $past(pulse_i)) != '0 || (RESTART && pulse_i != '0)));
endmodule

// File: rtl/bap_rd_mux.sv
module bap_rd_mux #(
  parameter int DW = 32,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] re_ext_i,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o
);
  import bap_pkg::*;

  localparam int W_ID = NW - 1;
  localparam logic [NW-1:0] MAPPED =
    (NW'(1) << W_OP_A) | (NW'(1) << W_OP_B) | (NW'(1) << W_SUM) | (NW'(1) << W_ID);

  logic [DW-1:0] sum;
  logic [DW-1:0] val;
  logic          hit;

  assign sum = op_a_i + op_b_i;
  assign hit = |(re_ext_i & MAPPED);

  always_comb begin
    val = '0;
    if (re_ext_i[W_OP_A]) val = op_a_i;
    if (re_ext_i[W_OP_B]) val = op_b_i;
    if (re_ext_i[W_SUM])  val = sum;
    if (re_ext_i[W_ID])   val = DW'(ID_WORD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      rdata_oe_o <= 1'b0;
    end else begin
      rdata_o    <= hit ? val : '0;
      rdata_oe_o <= hit;
    end
  end

  a_r4_sum_wraps: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(re_ext_i[W_SUM])) |-> (rdata_o == $past(op_a_i + op_b_i)));
  a_r5_id_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(re_ext_i[W_ID])) |-> (rdata_oe_o && rdata_o == 32'h3564A000));
  a_r6_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(re_ext_i != '0) && $past((re_ext_i & MAPPED) == '0))
      |-> (!rdata_oe_o && rdata_o == '0));
endmodule

// File: rtl/bus_adder_periph.sv
module bus_adder_periph #(
  parameter int DW  = 32,
  parameter int AW  = 5,
  parameter int EXT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          ctrl_sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o,
  output logic          rd_valid_o
);
  import bap_pkg::*;

  localparam int NW  = 1 << AW;
  localparam int NWR = 2;   // writable slots: operand A, operand B

  logic [AW-1:0]  addr_q;
  logic           ctrl_sel_q, wr_q, rd_q, rd_q_d;
  logic [DW-1:0]  wdata_q;
  logic [NW-1:0]  sel, re_pulse, re_ext;
  logic [NWR-1:0] we_pulse, we_ext, we_prev, op_load;
  logic [DW-1:0]  op_a, op_b;

  bap_in_sync #(.DW(DW), .AW(AW)) u_sync (
    .clk(clk), .rst(rst),
    .addr_i(addr_i), .ctrl_sel_i(ctrl_sel_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .addr_q(addr_q), .ctrl_sel_q(ctrl_sel_q), .wr_q(wr_q), .rd_q(rd_q), .wdata_q(wdata_q)
  );

  // One-hot word decode, gated by the control-region select
  assign sel      = ctrl_sel_q ? (NW'(1) << addr_q) : '0;
  assign re_pulse = rd_q ? sel : '0;
  assign we_pulse = wr_q ? {sel[W_OP_B], sel[W_OP_A]} : '0;

  bap_strobe_ext #(.N(NWR), .EXT(EXT), .RESTART(1'b0)) u_we_ext (
    .clk(clk), .rst(rst), .pulse_i(we_pulse), .ext_o(we_ext)
  );

  bap_strobe_ext #(.N(NW), .EXT(EXT), .RESTART(1'b1)) u_re_ext (
    .clk(clk), .rst(rst), .pulse_i(re_pulse), .ext_o(re_ext)
  );

  // Load only when a write window opens
  assign op_load = we_ext & ~we_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_prev    <= '0;
      op_a       <= '0;
      op_b       <= '0;
      rd_q_d     <= 1'b0;
      rd_valid_o <= 1'b0;
    end else begin
      we_prev    <= we_ext;
      if (op_load[0]) op_a <= wdata_q;
      if (op_load[1]) op_b <= wdata_q;
      rd_q_d     <= rd_q;
      rd_valid_o <= rd_q | rd_q_d;
    end
  end

  bap_rd_mux #(.DW(DW), .NW(NW)) u_mux (
    .clk(clk), .rst(rst), .re_ext_i(re_ext), .op_a_i(op_a), .op_b_i(op_b),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  a_r2_load_a: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_load[0])) |-> (op_a == $past(wdata_q)));
  a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we_prev[0]) && $past(we_ext[0])) |-> $stable(op_a));
  a_r8_valid_two: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid_o) |=> rd_valid_o);
endmodule

// File: tb/bus_adder_periph_tb.sv
module bus_adder_periph_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        csel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        oe, rvalid;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [4:0]  p_addr;
  logic        p_cs, p_wr, p_rd, p2_rd;
  logic [31:0] p_wd, m_a, m_b;
  int          age [2];
  bit          wact [2];
  int          rword, rage;
  logic [31:0] e_data;
  logic        e_oe, e_val;

  always #5 clk = ~clk;

  bus_adder_periph u_dut (
    .clk(clk), .rst(rst), .addr_i(addr), .ctrl_sel_i(csel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wd), .rdata_o(rdata), .rdata_oe_o(oe), .rd_valid_o(rvalid)
  );

  function automatic logic [31:0] word_val(int w);
    case (w)
      0:       return m_a;
      1:       return m_b;
      2:       return m_a + m_b;
      31:      return 32'h3564A000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    if (rst) begin
      p_addr = '0; p_cs = 0; p_wr = 0; p_rd = 0; p2_rd = 0; p_wd = '0;
      m_a = '0; m_b = '0;
      for (int n = 0; n < 2; n++) begin age[n] = 100; wact[n] = 0; end
      rword = 0; rage = 100;
      e_data = '0; e_oe = 0; e_val = 0;
    end else begin
      if (p_rd && p_cs) begin rword = int'(p_addr); rage = 0; end
      else if (rage < 100) rage++;
      if (rage <= 3 && (rword <= 2 || rword == 31)) begin
        e_oe = 1; e_data = word_val(rword);
      end else begin
        e_oe = 0; e_data = '0;
      end
      e_val = p_rd || p2_rd;
      for (int n = 0; n < 2; n++) begin
        bit hitw, act;
        hitw = p_wr && p_cs && (int'(p_addr) == n);
        act  = hitw || (age[n] + 1 <= 3);
        if (act && !wact[n]) begin
          if (n == 0) m_a = p_wd; else m_b = p_wd;
        end
        age[n]  = hitw ? 0 : (age[n] < 100 ? age[n] + 1 : 100);
        wact[n] = act;
      end
      p2_rd = p_rd;
      p_addr = addr; p_cs = csel; p_wr = wr; p_rd = rd; p_wd = wd;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (rdata !== e_data || oe !== e_oe || rvalid !== e_val) begin
      fails++;
      $display("FAIL %s: actual data=%h oe=%b valid=%b expected data=%h oe=%b valid=%b",
               cur_req, rdata, oe, rvalid, e_data, e_oe, e_val);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic c, input logic w,
                       input logic r, input logic [31:0] d);
    addr = a; csel = c; wr = w; rd = r; wd = d;
  endtask

  task automatic idle(input int n);
    drive(5'd0, 1'b0, 1'b0, 1'b0, 32'h0);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_word(input logic [4:0] a, input logic c, input logic [31:0] d);
    drive(a, c, 1'b1, 1'b0, d); tick(); idle(5);
  endtask

  task automatic rd_word(input logic [4:0] a, input logic c);
    drive(a, c, 1'b0, 1'b1, 32'hDEAD_BEEF); tick(); idle(6);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    drive(5'd0, 1'b0, 1'b0, 1'b0, 32'h0);
    cur_req = "R1";
    for (int i = 0; i < 3; i++) tick();
    rst = 1'b0;
    idle(2);
    rd_word(5'd0, 1); rd_word(5'd2, 1);

    cur_req = "R2";
    wr_word(5'd0, 1, 32'h1234_5678);
    wr_word(5'd1, 1, 32'h0000_1111);
    rd_word(5'd0, 1); rd_word(5'd1, 1);

    cur_req = "R7";
    rd_word(5'd2, 1);

    cur_req = "R8";
    rd_word(5'd2, 0);

    cur_req = "R3";
    wr_word(5'd0, 0, 32'hBAD0_0000);
    wr_word(5'd2, 1, 32'hBAD0_0002);
    wr_word(5'd31, 1, 32'hBAD0_001F);
    rd_word(5'd0, 1); rd_word(5'd1, 1);

    cur_req = "R5";
    rd_word(5'd31, 1);

    cur_req = "R6";
    rd_word(5'd5, 1); rd_word(5'd30, 1); rd_word(5'd31, 0);

    cur_req = "R4";
    wr_word(5'd0, 1, 32'hFFFF_FFF0);
    wr_word(5'd1, 1, 32'h0000_0020);
    rd_word(5'd2, 1);
    // live sum: operand changes while word 2 is shown
    drive(5'd2, 1, 0, 1, 32'h0); tick();
    drive(5'd0, 1, 1, 0, 32'h0000_0100); tick();
    idle(6);

    cur_req = "R9";
    drive(5'd0, 1, 1, 0, 32'hAAAA_0001); tick();
    drive(5'd0, 1, 1, 0, 32'hAAAA_0002); tick();
    drive(5'd0, 1, 1, 0, 32'hAAAA_0003); tick();
    idle(2);
    drive(5'd0, 1, 1, 0, 32'hAAAA_0004); tick();
    idle(4);
    rd_word(5'd0, 1);
    wr_word(5'd0, 1, 32'h5555_0005);
    rd_word(5'd0, 1);

    cur_req = "R10";
    drive(5'd0, 1, 0, 1, 32'h0); tick();
    drive(5'd31, 1, 0, 1, 32'h0); tick();
    drive(5'd9, 1, 0, 1, 32'h0); tick();
    drive(5'd1, 1, 0, 1, 32'h0); tick();
    idle(6);

    cur_req = "R2";
    lf = 32'hC0FF_EE11;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(lf[3] ? 5'(lf[5:4]) : (lf[6] ? 5'd31 : lf[12:8]),
            lf[14] | lf[15], lf[16] & lf[17], lf[18] & ~lf[17],
            {lf[15:0], lf[31:16]});
      tick();
    end
    idle(6);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule